// File: doc/BRIEF.md
# Three-Deep Receive Message FIFO

This block buffers up to three frames that a network controller has already received and accepted. A frame arrives on the write side as a data word together with a single-cycle valid strobe. The oldest stored frame is always presented on the read side as the output mailbox. The FIFO moves forward only when software asks it to release that mailbox.

Software reaches the block through two byte-wide registers on a small write-strobe interface with a combinational read path. The status register reports the pending count, a sticky full flag, a sticky overrun flag and a release command bit. The sticky flags are cleared by writing a one to them. The enable register holds eight mask bits.

A single level interrupt is the OR of the enabled sources. These are the full flag, the overrun flag, a latched message-pending event, and a transmit-complete input that comes from outside the block.

Top module: `rx_msg_fifo`

## Requirements
- R1: The block holds at most three frames. The status register (address 0) reports the number held in bits 1:0 as 0 to 3. `mbx_valid` is high exactly when that count is nonzero.
- R2: Each accepted frame raises the count by one. Each completed release lowers it by one. `mbx_data` always shows the oldest frame still held, so frames leave in the order they arrived.
- R3: Writing 1 to status bit 5 while frames are held requests a release. Bit 5 reads 1 in the cycle after the write. On the following clock edge the oldest frame is removed and bit 5 returns to 0.
- R4: A release request written while the count is 0 has no effect. Bit 5 stays 0, and a frame stored afterwards remains in the mailbox.
- R5: Status bit 3 (full) is set when the third frame is stored. It stays set as frames are released, and only a write with bit 3 set clears it.
- R6: A frame that arrives while three frames are held is discarded. This holds even when a release completes in the same cycle. The discarded frame sets status bit 4 (overrun), which only a write with bit 4 set clears. The stored frames and their order are not changed.
- R7: Status bits 7, 6 and 2 always read 0. Both registers read 00h after reset. Writing 0 to bits 4 and 3 leaves the flags unchanged.
- R8: The enable register at address 1 is readable and writable in all eight bits. From bit 7 down to bit 0 the bits are: wake-up, overrun (second FIFO), full (second FIFO), pending (second FIFO), overrun, full, pending, transmit-empty.
- R9: A message-pending event is latched when the count goes from 0 to 1, and a completed release clears it. It drives the interrupt only while enable bit 1 is set.
- R10: `irq` is high when any of these holds: the full flag with enable bit 2, the overrun flag with enable bit 3, or `tx_done` with enable bit 0. Enable bits 7 to 4 never affect `irq`.
- R11: When a frame is stored and a release completes in the same cycle with one or two frames held, the count is unchanged. The next frame in order becomes the mailbox, and the new frame is appended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_valid | input | 1 | One-cycle strobe for an accepted frame |
| frm_data | input | FRAME_W | Accepted frame contents |
| mbx_valid | output | 1 | Output mailbox holds a frame |
| mbx_data | output | FRAME_W | Oldest stored frame |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 status, 1 enable |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| tx_done | input | 1 | Transmit-complete event from outside the block |
| irq | output | 1 | Level interrupt |

## Verification
The assertions check the cycle-level rules on every clock: the count never exceeds three, it moves by exactly one per lone store, it holds when a store meets a release, and a dropped frame leaves it untouched. They also check that the release bit lasts one cycle, that a request while empty never arms it, and that full, overrun and the pending latch respond on the edge after their cause. Only the bench scenarios can show the frame order through the mailbox and the write-one-to-clear behaviour seen from software. The same holds for the reserved bits reading 0 after stray writes and for each interrupt source passing or being masked by its own enable bit.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam logic ADDR_STAT = 1'b0;
  localparam logic ADDR_IEN  = 1'b1;

  // status register bit positions
  localparam int ST_REL  = 5;
  localparam int ST_OVR  = 4;
  localparam int ST_FULL = 3;

  // enable register bit positions used by this block
  localparam int IE_TXE  = 0;
  localparam int IE_PEND = 1;
  localparam int IE_FULL = 2;
  localparam int IE_OVR  = 3;
endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
  parameter int FRAME_W = 16,
  parameter int DEPTH   = 3,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push,
  input  logic [FRAME_W-1:0] din,
  input  logic               pop,
  output logic [FRAME_W-1:0] dout,
  output logic [CNT_W-1:0]   cnt,
  output logic               accept,
  output logic               drop,
  output logic               hit_full,
  output logic               first_msg
);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [FRAME_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]   head_q, head_d, tail_q, tail_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               pop_ok;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  // next-state
  always_comb begin
    accept    = push && (cnt_q != CNT_MAX);
    drop      = push && (cnt_q == CNT_MAX);
    pop_ok    = pop && (cnt_q != '0);
    head_d    = pop_ok ? ptr_inc(head_q) : head_q;
    tail_d    = accept ? ptr_inc(tail_q) : tail_q;
    cnt_d     = cnt_q;
    if (accept && !pop_ok)      cnt_d = cnt_q + 1'b1;
    else if (!accept && pop_ok) cnt_d = cnt_q - 1'b1;
    hit_full  = accept && (cnt_d == CNT_MAX);
    first_msg = accept && (cnt_q == '0);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic slot_en;
    assign slot_en = accept && (tail_q == PTR_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mem_q[i] <= '0;
      else if (slot_en) mem_q[i] <= din;
    end
  end

  assign dout = mem_q[head_q];
  assign cnt  = cnt_q;

  assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX);
  assert_cnt_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + 1'b1);
  assert_drop_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (drop && !pop) |=> (cnt_q == $past(cnt_q)) && (tail_q == $past(tail_q)));
  assert_simul_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && cnt_q != '0 && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q));
endmodule

// File: rtl/rxf_regs.sv
module rxf_regs
  import rxf_pkg::*;
#(
  parameter int DEPTH  = 3,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             addr,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata,
  input  logic [CNT_W-1:0] cnt,
  input  logic             accept,
  input  logic             drop,
  input  logic             hit_full,
  input  logic             first_msg,
  input  logic             tx_done,
  output logic             pop,
  output logic             irq
);
  logic       stat_wr, ien_wr;
  logic       rel_q, rel_d;
  logic       ovr_q, ovr_d;
  logic       full_q, full_d;
  logic       pend_q, pend_d;
  logic [7:0] ien_q;
  logic [1:0] cnt_field;

  assign stat_wr   = wr_en && (addr == ADDR_STAT);
  assign ien_wr    = wr_en && (addr == ADDR_IEN);
  assign cnt_field = 2'(cnt);

  // next-state
  always_comb begin
    rel_d  = rel_q ? 1'b0 : (stat_wr && wdata[ST_REL] && (cnt != '0));
    ovr_d  = drop || (ovr_q && !(stat_wr && wdata[ST_OVR]));
    full_d = hit_full || (full_q && !(stat_wr && wdata[ST_FULL]));
    pend_d = first_msg || (pend_q && !rel_q);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel_q  <= 1'b0;
      ovr_q  <= 1'b0;
      full_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      rel_q  <= rel_d;
      ovr_q  <= ovr_d;
      full_q <= full_d;
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ien_q <= 8'h00;
    else if (ien_wr) ien_q <= wdata;
  end

  assign pop   = rel_q;
  assign rdata = (addr == ADDR_STAT) ?
                 {2'b00, rel_q, ovr_q, full_q, 1'b0, cnt_field} : ien_q;
  assign irq   = (pend_q  && ien_q[IE_PEND]) ||
                 (full_q  && ien_q[IE_FULL]) ||
                 (ovr_q   && ien_q[IE_OVR])  ||
                 (tx_done && ien_q[IE_TXE]);

  assert_rel_oneshot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rel_q |=> !rel_q);
  assert_rel_has_msg_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rel_q |-> cnt != '0);
  assert_empty_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && wdata[ST_REL] && cnt == '0 && !rel_q) |=> !rel_q);
  assert_full_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hit_full |=> full_q);
  assert_ovr_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> ovr_q);
  assert_pend_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_q && !accept) |=> !pend_q);
endmodule

// File: rtl/rx_msg_fifo.sv
module rx_msg_fifo #(
  parameter int FRAME_W = 16,
  parameter int DEPTH   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frm_valid,
  input  logic [FRAME_W-1:0] frm_data,
  output logic               mbx_valid,
  output logic [FRAME_W-1:0] mbx_data,
  input  logic               reg_wr,
  input  logic               reg_addr,
  input  logic [7:0]         reg_wdata,
  output logic [7:0]         reg_rdata,
  input  logic               tx_done,
  output logic               irq
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] cnt;
  logic             pop, accept, drop, hit_full, first_msg;

  rxf_store #(.FRAME_W(FRAME_W), .DEPTH(DEPTH)) store_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (frm_valid),
    .din       (frm_data),
    .pop       (pop),
    .dout      (mbx_data),
    .cnt       (cnt),
    .accept    (accept),
    .drop      (drop),
    .hit_full  (hit_full),
    .first_msg (first_msg)
  );

  rxf_regs #(.DEPTH(DEPTH)) regs_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (reg_wr),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .rdata     (reg_rdata),
    .cnt       (cnt),
    .accept    (accept),
    .drop      (drop),
    .hit_full  (hit_full),
    .first_msg (first_msg),
    .tx_done   (tx_done),
    .pop       (pop),
    .irq       (irq)
  );

  assign mbx_valid = (cnt != '0);
endmodule

// File: tb/rx_msg_fifo_tb_top.sv
`timescale 1ns/1ps
module rx_msg_fifo_tb_top;
  localparam int FW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          frm_valid;
  logic [FW-1:0] frm_data;
  logic          mbx_valid;
  logic [FW-1:0] mbx_data;
  logic          reg_wr;
  logic          reg_addr;
  logic [7:0]    reg_wdata;
  logic [7:0]    reg_rdata;
  logic          tx_done;
  logic          irq;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  rx_msg_fifo #(.FRAME_W(FW), .DEPTH(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_data(frm_data),
    .mbx_valid(mbx_valid), .mbx_data(mbx_data), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_done(tx_done), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; frm_valid = 1'b0; frm_data = '0; reg_wr = 1'b0;
    reg_addr = 1'b0; reg_wdata = 8'h00; tx_done = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic push(input logic [FW-1:0] d);
    frm_valid = 1'b1; frm_data = d;
    @(negedge clk);
    frm_valid = 1'b0;
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = 8'h00;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic release_one();
    wr(1'b0, 8'h20);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    do_reset();
    rd(1'b0, v); chk("R7 status reset", v, 8'h00);
    rd(1'b1, v); chk("R7 enable reset", v, 8'h00);
    chk("R1 mbx_valid reset", mbx_valid, 0);
    chk("R10 irq reset", irq, 0);
  endtask

  task automatic t_fill_order();
    logic [7:0] v;
    do_reset();
    push(16'hA001); rd(1'b0, v); chk("R1 count 1", v, 8'h01);
    chk("R1 mbx_valid", mbx_valid, 1);
    push(16'hA002); rd(1'b0, v); chk("R2 count 2", v, 8'h02);
    push(16'hA003); rd(1'b0, v); chk("R5 full on third", v, 8'h0B);
    chk("R2 oldest first", mbx_data, 16'hA001);
    wr(1'b0, 8'h20); rd(1'b0, v); chk("R3 release bit reads 1", v, 8'h2B);
    @(negedge clk); rd(1'b0, v); chk("R3 release done", v, 8'h0A);
    chk("R2 second frame", mbx_data, 16'hA002);
    release_one(); chk("R2 third frame", mbx_data, 16'hA003);
    release_one(); rd(1'b0, v); chk("R5 full sticky at empty", v, 8'h08);
    chk("R1 mbx_valid empty", mbx_valid, 0);
    wr(1'b0, 8'h00); rd(1'b0, v); chk("R7 zero write keeps flag", v, 8'h08);
    wr(1'b0, 8'h08); rd(1'b0, v); chk("R5 full cleared", v, 8'h00);
  endtask

  task automatic t_overrun();
    logic [7:0] v;
    do_reset();
    push(16'hB001); push(16'hB002); push(16'hB003); push(16'hB004);
    rd(1'b0, v); chk("R6 overrun set", v, 8'h1B);
    chk("R6 mailbox unchanged", mbx_data, 16'hB001);
    release_one(); chk("R6 order kept 2", mbx_data, 16'hB002);
    release_one(); chk("R6 order kept 3", mbx_data, 16'hB003);
    release_one(); chk("R6 dropped frame absent", mbx_valid, 0);
    wr(1'b0, 8'h10); rd(1'b0, v); chk("R6 overrun cleared", v, 8'h08);
  endtask

  task automatic t_rel_empty();
    logic [7:0] v;
    do_reset();
    wr(1'b0, 8'h20); rd(1'b0, v); chk("R4 release ignored when empty", v, 8'h00);
    push(16'hC001);
    @(negedge clk); @(negedge clk);
    rd(1'b0, v); chk("R4 later frame kept", v, 8'h01);
    chk("R4 mailbox frame", mbx_data, 16'hC001);
  endtask

  task automatic t_reserved();
    logic [7:0] v;
    do_reset();
    push(16'hD001); push(16'hD002); push(16'hD003);
    wr(1'b0, 8'hC4); rd(1'b0, v); chk("R7 reserved write", v, 8'h0B);
  endtask

  task automatic t_ien();
    logic [7:0] v;
    do_reset();
    wr(1'b1, 8'hA5); rd(1'b1, v); chk("R8 enable rw A5", v, 8'hA5);
    wr(1'b1, 8'h5A); rd(1'b1, v); chk("R8 enable rw 5A", v, 8'h5A);
  endtask

  task automatic t_irq_pending();
    do_reset();
    wr(1'b1, 8'h02);
    push(16'hE001); #1; chk("R9 pending irq on 0 to 1", irq, 1);
    push(16'hE002); #1; chk("R9 pending held", irq, 1);
    release_one(); #1; chk("R9 cleared by release", irq, 0);
    release_one(); push(16'hE003); #1; chk("R9 pending again", irq, 1);
    wr(1'b1, 8'h00); #1; chk("R9 masked", irq, 0);
    wr(1'b1, 8'h02); #1; chk("R9 unmasked latched", irq, 1);
  endtask

  task automatic t_irq_other();
    do_reset();
    wr(1'b1, 8'hF0);
    push(16'hF001); push(16'hF002); push(16'hF003); push(16'hF004);
    tx_done = 1'b1; #1; chk("R10 high enables ignored", irq, 0);
    tx_done = 1'b0;
    wr(1'b1, 8'h04); #1; chk("R10 full irq", irq, 1);
    wr(1'b0, 8'h08); #1; chk("R10 full cleared irq", irq, 0);
    wr(1'b1, 8'h08); #1; chk("R10 overrun irq", irq, 1);
    wr(1'b1, 8'h01); #1; chk("R10 tx idle", irq, 0);
    tx_done = 1'b1; #1; chk("R10 tx irq", irq, 1);
    wr(1'b1, 8'h00); #1; chk("R10 tx masked", irq, 0);
    tx_done = 1'b0;
  endtask

  task automatic t_simul();
    logic [7:0] v;
    do_reset();
    push(16'h1001);
    wr(1'b0, 8'h20); push(16'h1002);
    rd(1'b0, v); chk("R11 count held at 1", v, 8'h01);
    chk("R11 next frame in mailbox", mbx_data, 16'h1002);
    do_reset();
    push(16'h2001); push(16'h2002);
    wr(1'b0, 8'h20); push(16'h2003);
    rd(1'b0, v); chk("R11 count held at 2", v, 8'h02);
    chk("R11 mailbox advanced", mbx_data, 16'h2002);
    release_one(); chk("R11 appended frame", mbx_data, 16'h2003);
    do_reset();
    push(16'h3001); push(16'h3002); push(16'h3003);
    wr(1'b0, 8'h20); push(16'h3004);
    rd(1'b0, v); chk("R6 drop with release", v, 8'h1A);
    release_one(); chk("R6 order after drop", mbx_data, 16'h3003);
    release_one(); chk("R6 frame discarded", mbx_valid, 0);
  endtask

  initial begin
    rst_n = 1'b0; frm_valid = 1'b0; frm_data = '0; reg_wr = 1'b0;
    reg_addr = 1'b0; reg_wdata = 8'h00; tx_done = 1'b0;
    t_reset();
    t_fill_order();
    t_overrun();
    t_rel_empty();
    t_reserved();
    t_ien();
    t_irq_pending();
    t_irq_other();
    t_simul();
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end
endmodule